// File: doc/BRIEF.md
# System-Management Memory Access Controller

This block holds the two byte-wide control registers that govern a protected system-management memory area and turns their contents into routing decisions. A host writes the registers through a small byte-enabled write port and reads them back on a parallel output. For each access it is shown (an address plus a flag saying whether the requester is in system-management mode), the block returns a two-bit route: leave the access to the default system map, send it to device space, send it to RAM, or sink it in a blackhole that reads as all-ones and drops writes.

Three address ranges are governed: the legacy low window (0xA0000 to 0xBFFFF), a high alias of the same RAM at 0xFEDA0000 of equal size, and a top segment of selectable size ending at the top of low memory. A sticky lock bit closes the open path and freezes most of the control bits until reset. Decoding is combinational from the registers, so a new setting governs accesses from the clock edge that stores it.

Top module: `smm_mem_ctl`

## Requirements
- R1: After reset `cfg_rdata` is 16'h0002 (main register in bits [7:0], extended register in bits [15:8]); `norm_low_dev` is 1 and `norm_high_vis`, `smm_low_ram`, `smm_high_ram`, `tseg_active` are 0.
- R2: Main register bits: open = 6, close = 5, lock = 4, global-enable = 3, bit 7 reads 0 and bits [2:0] always read 3'b010. Extended register bits: high-enable = 7, size field = [2:1], top-segment enable = 0, bits [6:3] read 0. While unlocked, main bits [6:3] and extended bits 7, [2:0] are writable; `cfg_be[0]` enables the main byte (`cfg_wdata[7:0]`) and `cfg_be[1]` the extended byte (`cfg_wdata[15:8]`).
- R3: Writing lock = 1 forces open to 0 in that same write; from then on only global-enable of the main register can change, lock cannot be cleared, and the extended register does not change, until reset.
- R4: An extended-register byte written in the same write that first sets lock is stored with the unlocked write mask.
- R5: For normal accesses in the low window the route is RAM when open = 1 and high-enable = 0, otherwise device; `norm_low_dev` is 1 exactly in the device case.
- R6: For normal accesses in the high alias window the route is RAM when open = 1 and high-enable = 1, otherwise default; `norm_high_vis` reflects that condition.
- R7: A system-management access is routed to RAM in the low window when global-enable = 1 and high-enable = 0 (`smm_low_ram`), and in the high window when global-enable = 1 and high-enable = 1 (`smm_high_ram`); otherwise it follows the normal-access rule.
- R8: The top-segment size is 1 MiB, 2 MiB or 8 MiB for size field 00, 01, 10 with enable = 1, and zero for field 11 or enable = 0; `tseg_base` equals top of low memory minus the size and `tseg_active` is 1 when the size is non-zero.
- R9: An address in [`tseg_base`, top of low memory) with non-zero size routes to blackhole for normal accesses and to RAM for system-management accesses.
- R10: Route encoding: 2'b00 default map, 2'b01 device, 2'b10 RAM, 2'b11 blackhole; every address outside the three ranges routes to 2'b00.
- R11: Register contents, visibility outputs and routes reflect a write from the clock edge on which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_be | input | 2 | Byte enables: bit 0 main, bit 1 extended |
| cfg_wdata | input | 16 | Write data, main in [7:0], extended in [15:8] |
| cfg_rdata | output | 16 | Register read-back, same layout |
| acc_addr | input | ADDR_W | Address of the access being routed |
| acc_smm | input | 1 | Access made in system-management mode |
| acc_route | output | 2 | Route decision for the access |
| norm_low_dev | output | 1 | Low window goes to device space for normal accesses |
| norm_high_vis | output | 1 | High alias visible to normal accesses |
| smm_low_ram | output | 1 | Low window RAM for system-management accesses |
| smm_high_ram | output | 1 | High alias RAM for system-management accesses |
| tseg_active | output | 1 | Top segment has non-zero size |
| tseg_base | output | ADDR_W | Lowest address of the top segment |

## Verification
The hardest situation to reach is the write that sets lock while also carrying open = 1 and a new extended byte, because it must store the extended byte with the old mask yet clear open in the same edge; the bench issues exactly that single two-byte write and then tries to undo each frozen bit. Routing is swept over every combination of open, high-enable, global-enable and all eight low extended-bit codes, probing both edges of each range and the addresses just outside, in both access modes.

// File: rtl/smm_mem_pkg.sv
package smm_mem_pkg;

   typedef enum logic [1:0] {
      RT_PASS = 2'b00,
      RT_DEV  = 2'b01,
      RT_RAM  = 2'b10,
      RT_HOLE = 2'b11
   } route_e;

   localparam int MB_OPEN  = 6;
   localparam int MB_CLOSE = 5;
   localparam int MB_LOCK  = 4;
   localparam int MB_GEN   = 3;

   localparam int XB_HEN   = 7;
   localparam int XB_SZ_LO = 1;
   localparam int XB_TEN   = 0;

   localparam logic [7:0] MAIN_FIXED    = 8'h02;
   localparam logic [7:0] MAIN_FIX_MASK = 8'h07;
   localparam logic [7:0] MAIN_WM_OPEN  = 8'h78;
   localparam logic [7:0] MAIN_WM_LOCK  = 8'h08;
   localparam logic [7:0] EXT_RESET     = 8'h00;
   localparam logic [7:0] EXT_WM_OPEN   = 8'h87;
   localparam logic [7:0] EXT_WM_LOCK   = 8'h00;

endpackage

// File: rtl/smm_mem_regs.sv
module smm_mem_regs
   import smm_mem_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] be,
   input  logic [15:0] wdata,
   output logic [7:0] main_q,
   output logic [7:0] ext_q
);

   logic [7:0] main_wm, ext_wm;
   logic [7:0] main_n, ext_n;
   logic       locked;

   assign locked = main_q[MB_LOCK];

   always_comb begin
      main_wm = locked ? MAIN_WM_LOCK : MAIN_WM_OPEN;
      ext_wm  = locked ? EXT_WM_LOCK  : EXT_WM_OPEN;
      main_n  = main_q;
      ext_n   = ext_q;
      if (wr && be[0]) begin
         main_n = (main_q & ~main_wm) | (wdata[7:0] & main_wm);
      end
      if (wr && be[1]) begin
         ext_n = (ext_q & ~ext_wm) | (wdata[15:8] & ext_wm);
      end
      main_n = (main_n & ~MAIN_FIX_MASK) | MAIN_FIXED;
      if (main_n[MB_LOCK] || locked) begin
         main_n[MB_LOCK] = 1'b1;
         main_n[MB_OPEN] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         main_q <= MAIN_FIXED;
         ext_q  <= EXT_RESET;
      end else begin
         main_q <= main_n;
         ext_q  <= ext_n;
      end
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      main_q[MB_LOCK] |=> main_q[MB_LOCK]); // R3
   AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      main_q[MB_LOCK] |=> $stable(ext_q)); // R3
   AST_OPEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      main_q[MB_LOCK] |-> !main_q[MB_OPEN]); // R3

endmodule

// File: rtl/smm_mem_tseg.sv
module smm_mem_tseg #(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h8000_0000,
   parameter bit MASK_CMP = 1'b1
) (
   input  logic              en,
   input  logic [1:0]        sz,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] size,
   output logic [ADDR_W-1:0] base,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] ONE_MIB = ADDR_W'(1) << 20;

   initial begin
      assert (ADDR_W >= 32) else $error("address width below 32");
      assert (TOLM >= (ONE_MIB << 3)) else $error("top of low memory below 8 MiB");
      assert (!MASK_CMP || (TOLM % (ONE_MIB << 3)) == 0)
         else $error("mask compare needs 8 MiB aligned top of low memory");
   end

   always_comb begin
      size = '0;
      if (en) begin
         case (sz)
            2'b00:   size = ONE_MIB;
            2'b01:   size = ONE_MIB << 1;
            2'b10:   size = ONE_MIB << 3;
            default: size = '0;
         endcase
      end
   end

   assign base = TOLM - size;

   generate
      if (MASK_CMP) begin : g_mask
         assign hit = (size != '0) && ((addr & ~(size - ADDR_W'(1))) == base);
      end else begin : g_cmp
         assign hit = (size != '0) && (addr >= base) && (addr < TOLM);
      end
   endgenerate

endmodule

// File: rtl/smm_mem_route.sv
module smm_mem_route
   import smm_mem_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
   parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
   parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0002_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              smm,
   input  logic              open,
   input  logic              hen,
   input  logic              gen,
   input  logic              tseg_hit,
   output logic [1:0]        route,
   output logic              in_low,
   output logic              low_dev,
   output logic              high_vis,
   output logic              smm_low,
   output logic              smm_high
);

   localparam int NWIN = 2;
   localparam logic [ADDR_W-1:0] WBASE [NWIN] = '{LOW_BASE, HIGH_BASE};

   logic [NWIN-1:0] win_hit;

   initial begin
      assert (HIGH_BASE > LOW_BASE + WIN_SIZE) else $error("windows overlap");
      assert (HIGH_BASE + WIN_SIZE > HIGH_BASE) else $error("high window wraps");
   end

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         assign win_hit[w] = (addr >= WBASE[w]) && (addr < WBASE[w] + WIN_SIZE);
      end
   endgenerate

   assign in_low   = win_hit[0];
   assign low_dev  = !(open && !hen);
   assign high_vis = open && hen;
   assign smm_low  = gen && !hen;
   assign smm_high = gen && hen;

   route_e r;
   always_comb begin
      r = RT_PASS;
      if (win_hit[0]) begin
         if (smm && smm_low)   r = RT_RAM;
         else if (low_dev)     r = RT_DEV;
         else                  r = RT_RAM;
      end else if (win_hit[1]) begin
         if (smm && smm_high)  r = RT_RAM;
         else if (high_vis)    r = RT_RAM;
         else                  r = RT_PASS;
      end else if (tseg_hit) begin
         r = smm ? RT_RAM : RT_HOLE;
      end
   end
   assign route = r;

endmodule

// File: rtl/smm_mem_ctl.sv
module smm_mem_ctl
   import smm_mem_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] TOLM      = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
   parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
   parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0002_0000,
   parameter bit TSEG_MASK_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_be,
   input  logic [15:0]       cfg_wdata,
   output logic [15:0]       cfg_rdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   output logic [1:0]        acc_route,
   output logic              norm_low_dev,
   output logic              norm_high_vis,
   output logic              smm_low_ram,
   output logic              smm_high_ram,
   output logic              tseg_active,
   output logic [ADDR_W-1:0] tseg_base
);

   logic [7:0]        main_q, ext_q;
   logic [ADDR_W-1:0] tseg_size;
   logic              tseg_hit, in_low;

   initial begin
      assert (TOLM <= HIGH_BASE) else $error("top of low memory above high alias");
      assert (TOLM >= LOW_BASE + WIN_SIZE + (ADDR_W'(1) << 23))
         else $error("top segment could overlap the low window");
   end

   smm_mem_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cfg_wr),
      .be     (cfg_be),
      .wdata  (cfg_wdata),
      .main_q (main_q),
      .ext_q  (ext_q)
   );

   smm_mem_tseg #(
      .ADDR_W   (ADDR_W),
      .TOLM     (TOLM),
      .MASK_CMP (TSEG_MASK_CMP)
   ) u_tseg (
      .en   (ext_q[XB_TEN]),
      .sz   (ext_q[XB_SZ_LO+1:XB_SZ_LO]),
      .addr (acc_addr),
      .size (tseg_size),
      .base (tseg_base),
      .hit  (tseg_hit)
   );

   smm_mem_route #(
      .ADDR_W    (ADDR_W),
      .LOW_BASE  (LOW_BASE),
      .HIGH_BASE (HIGH_BASE),
      .WIN_SIZE  (WIN_SIZE)
   ) u_route (
      .addr     (acc_addr),
      .smm      (acc_smm),
      .open     (main_q[MB_OPEN]),
      .hen      (ext_q[XB_HEN]),
      .gen      (main_q[MB_GEN]),
      .tseg_hit (tseg_hit),
      .route    (acc_route),
      .in_low   (in_low),
      .low_dev  (norm_low_dev),
      .high_vis (norm_high_vis),
      .smm_low  (smm_low_ram),
      .smm_high (smm_high_ram)
   );

   assign cfg_rdata   = {ext_q, main_q};
   assign tseg_active = (tseg_size != '0);

   AST_HOLE_NORMAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_route == RT_HOLE) |-> !acc_smm); // R9
   AST_LOW_NEVER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      in_low |-> (acc_route != RT_PASS)); // R5
   AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tseg_size)); // R8
   AST_HOLE_IN_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_route == RT_HOLE) |-> (acc_addr >= tseg_base && acc_addr < TOLM)); // R9
   AST_LOCK_HIDES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      main_q[MB_LOCK] |-> !norm_high_vis); // R3

endmodule

// File: tb/smm_mem_ctl_tb.sv
`timescale 1ns/1ps
module smm_mem_ctl_tb;

   localparam logic [31:0] TOLM = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_be = 2'b00;
   logic [15:0] cfg_wdata = 16'h0;
   logic [15:0] cfg_rdata;
   logic [31:0] acc_addr = 32'h0;
   logic        acc_smm = 1'b0;
   logic [1:0]  acc_route;
   logic        norm_low_dev, norm_high_vis, smm_low_ram, smm_high_ram, tseg_active;
   logic [31:0] tseg_base;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   smm_mem_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
      .acc_smm(acc_smm), .acc_route(acc_route), .norm_low_dev(norm_low_dev),
      .norm_high_vis(norm_high_vis), .smm_low_ram(smm_low_ram),
      .smm_high_ram(smm_high_ram), .tseg_active(tseg_active), .tseg_base(tseg_base)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = 2'b00;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   function automatic logic [31:0] size_of(input logic [2:0] code);
      if (!code[0]) return 32'h0;
      case (code[2:1])
         2'b00:   return 32'h0010_0000;
         2'b01:   return 32'h0020_0000;
         2'b10:   return 32'h0080_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [1:0] exp_route(input bit o, input bit h, input bit g,
         input logic [31:0] sz, input logic [31:0] a, input bit smm);
      if (a >= 32'h000A_0000 && a < 32'h000C_0000) begin
         if (smm && g && !h) return 2'b10;
         return (o && !h) ? 2'b10 : 2'b01;
      end
      if (a >= 32'hFEDA_0000 && a < 32'hFEDC_0000) begin
         if (smm && g && h) return 2'b10;
         return (o && h) ? 2'b10 : 2'b00;
      end
      if (sz != 0 && a >= TOLM - sz && a < TOLM) return smm ? 2'b10 : 2'b11;
      return 2'b00;
   endfunction

   function automatic string tag_of(input int idx);
      if (idx <= 1) return "R5 R7 low";
      if (idx <= 3) return "R10 low edge";
      if (idx <= 5) return "R6 R7 high";
      if (idx == 6) return "R10 high edge";
      if (idx == 7 || idx == 10) return "R9 R10 seg edge";
      return "R9 seg";
   endfunction

   initial begin
      #(5.0 * 150000);
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 rdata", {16'h0, cfg_rdata}, 32'h0002);
      chk("R1 low_dev", {31'h0, norm_low_dev}, 32'h1);
      chk("R1 high_vis", {31'h0, norm_high_vis}, 32'h0);
      chk("R1 smm_low", {31'h0, smm_low_ram}, 32'h0);
      chk("R1 smm_high", {31'h0, smm_high_ram}, 32'h0);
      chk("R1 tseg", {31'h0, tseg_active}, 32'h0);

      // R2 write masks and byte enables
      wr(2'b11, 16'hFFE8);
      chk("R2 mask main", {24'h0, cfg_rdata[7:0]}, 32'h6A);
      chk("R2 mask ext", {24'h0, cfg_rdata[15:8]}, 32'h87);
      wr(2'b01, 16'h0000);
      chk("R2 be main", {24'h0, cfg_rdata[7:0]}, 32'h02);
      chk("R2 be ext kept", {24'h0, cfg_rdata[15:8]}, 32'h87);
      wr(2'b10, 16'h00FF);
      chk("R2 be main kept", {24'h0, cfg_rdata[7:0]}, 32'h02);
      chk("R2 be ext", {24'h0, cfg_rdata[15:8]}, 32'h00);

      // Sweep: open, high-enable, global-enable, extended low code
      for (int o = 0; o < 2; o++) begin
         for (int h = 0; h < 2; h++) begin
            for (int g = 0; g < 2; g++) begin
               for (int c = 0; c < 8; c++) begin
                  logic [7:0]  mb, xb;
                  logic [31:0] sz;
                  logic [31:0] ad [11];
                  mb = 8'h02 | (8'(o) << 6) | (8'(g) << 3);
                  xb = (8'(h) << 7) | 8'(c);
                  sz = size_of(3'(c));
                  wr(2'b11, {xb, mb});
                  chk("R11 R2 rdata", {16'h0, cfg_rdata}, {16'h0, xb, mb});
                  chk("R11 R5 low_dev", {31'h0, norm_low_dev}, {31'h0, !(o == 1 && h == 0)});
                  chk("R11 R6 high_vis", {31'h0, norm_high_vis}, {31'h0, (o == 1 && h == 1)});
                  chk("R11 R7 smm_low", {31'h0, smm_low_ram}, {31'h0, (g == 1 && h == 0)});
                  chk("R11 R7 smm_high", {31'h0, smm_high_ram}, {31'h0, (g == 1 && h == 1)});
                  chk("R8 active", {31'h0, tseg_active}, {31'h0, sz != 0});
                  chk("R8 base", tseg_base, TOLM - sz);
                  ad[0] = 32'h000A_0000; ad[1] = 32'h000B_FFFF;
                  ad[2] = 32'h000C_0000; ad[3] = 32'h0009_FFFF;
                  ad[4] = 32'hFEDA_0000; ad[5] = 32'hFEDB_FFFF;
                  ad[6] = 32'hFEDC_0000; ad[7] = TOLM - sz - 1;
                  ad[8] = TOLM - sz;     ad[9] = TOLM - 1;
                  ad[10] = TOLM;
                  for (int i = 0; i < 11; i++) begin
                     for (int s = 0; s < 2; s++) begin
                        acc_addr = ad[i];
                        acc_smm = (s == 1);
                        #1;
                        chk(tag_of(i), {30'h0, acc_route},
                            {30'h0, exp_route(o == 1, h == 1, g == 1, sz, ad[i], s == 1)});
                     end
                  end
               end
            end
         end
      end

      // R3 / R4 lock behaviour
      do_reset();
      wr(2'b11, 16'h835A);
      chk("R3 open forced low", {24'h0, cfg_rdata[7:0]}, 32'h1A);
      chk("R4 ext same write", {24'h0, cfg_rdata[15:8]}, 32'h83);
      chk("R3 high hidden", {31'h0, norm_high_vis}, 32'h0);
      wr(2'b01, 16'h0048);
      chk("R3 open stays low", {24'h0, cfg_rdata[7:0]}, 32'h1A);
      wr(2'b01, 16'h0000);
      chk("R3 gen writable lock sticky", {24'h0, cfg_rdata[7:0]}, 32'h12);
      wr(2'b10, 16'h0000);
      chk("R3 ext frozen", {24'h0, cfg_rdata[15:8]}, 32'h83);
      chk("R3 seg kept", tseg_base, TOLM - 32'h0020_0000);
      acc_addr = 32'h000A_0000; acc_smm = 1'b0; #1;
      chk("R3 low dev after lock", {30'h0, acc_route}, 32'h1);
      do_reset();
      chk("R3 R1 reset clears lock", {16'h0, cfg_rdata}, 32'h0002);
      wr(2'b11, 16'h0540);
      chk("R3 writable after reset", {16'h0, cfg_rdata}, 32'h0542);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule